// File: doc/BRIEF.md
# Audio Control-Register I2C Write Target

This block is the serial control port of an audio processor. It listens to a two-wire I2C bus through a fast system clock, frames transfers by their START and STOP conditions, and accepts only write transfers sent to its fixed 7-bit device address. After the address, the first byte chooses a register and carries an auto-increment flag. Every byte after that is control data.

Data bytes land in a small bank of 8-bit control registers. Those registers hold the settings for input selection, gain control, surround, volume, tone and the two balance attenuators. When auto-increment is off, every data byte rewrites the chosen register. When it is on, a 4-bit pointer advances after each byte and wraps from 15 to 0. Pointer positions with no register behind them accept the byte and acknowledge it, but store nothing. The target acknowledges by pulling SDA low through an open-drain enable.

Software sees the register values as one flat bus. Each stored byte also raises a one-cycle strobe that carries its register index.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. After a STOP the target is idle, its SDA pull is released, and it waits for a START.
- R2: The target acknowledges the address byte only when it equals 0x88, which is device address 1000100 followed by a write bit of 0. After any other address byte it gives no acknowledge, stores nothing, and acknowledges nothing until the next START.
- R3: A read request (address byte 0x89) is not acknowledged.
- R4: The byte after a matched address is the subaddress and is acknowledged. Its bits 3:0 load the register pointer, bit 4 is the auto-increment flag, and bits 7:5 have no effect.
- R5: With the auto-increment flag at 0, every data byte up to the STOP is written to the register the pointer selects.
- R6: With the auto-increment flag at 1, the first data byte goes to the pointer position. Each following byte goes to the previous position plus one, modulo 16. A position of 7 or more stores nothing.
- R7: After reset all seven registers read 0xFE. Register i sits in bits 8*i+7 down to 8*i of the flat output.
- R8: Each stored byte raises the write strobe for exactly one cycle, with the register index 0 to 6 it was written to. Bytes aimed at positions 7 to 15 raise no strobe.
- R9: A repeated START inside a transfer restarts address matching. The transfer that follows it behaves as a new one.
- R10: Every data byte of an addressed transfer is acknowledged, including bytes aimed at positions with no register. The SDA pull changes only while SCL is low.
- R11: A STOP partway through a data byte discards the partial byte and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | I2C clock line as seen on the bus |
| sdaIn | input | 1 | I2C data line as seen on the bus |
| sdaPullEn | output | 1 | When high, the open-drain driver pulls SDA low |
| regFlat | output | NUM_REGS*8 | All control registers; register i in bits 8*i+7:8*i |
| wrStrobe | output | 1 | One-cycle pulse for each stored data byte |
| wrIndex | output | PTR_W | Index of the register written with wrStrobe |

## Verification
The bench uses the default parameters: seven registers, a 4-bit pointer, device address 0x44 and a two-stage synchronizer. Because the pointer range is larger than the register count, one 13-byte burst that starts at position 5 reaches the last two real registers, then the nine positions with no register, then the wrap back to registers 0 and 1. A bit period of forty system clocks leaves room for the synchronizer delay, so acknowledge timing, repeated STARTs and a STOP in the middle of a byte can each be checked at the pins.

// File: rtl/actl_pkg.sv
package actl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_ACK,
    ST_IGNORE
  } busState_t;

  typedef struct packed {
    logic shiftEn;
    logic loadSub;
    logic writeData;
  } ctrlStrobes_t;

endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclChain;
  logic [STAGES-1:0] sdaChain;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclChain <= {sclChain[STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[STAGES-2:0], sdaIn};
      sclPrev  <= sclChain[STAGES-1];
      sdaPrev  <= sdaChain[STAGES-1];
    end
  end

  assign sclLvl    = sclChain[STAGES-1];
  assign sdaLvl    = sdaChain[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/actl_ctrl.sv
module actl_ctrl
  import actl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclLvl,
  input  logic         sclRise,
  input  logic         sclFall,
  input  logic         startSeen,
  input  logic         stopSeen,
  input  logic         addrMatch,
  output ctrlStrobes_t strb,
  output logic         sdaPull
);

  busState_t state;
  busState_t afterAck;
  logic [2:0] bitCnt;
  logic inByte;
  logic byteDone;

  assign inByte   = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
  assign byteDone = strb.shiftEn && (bitCnt == 3'd7);

  always_comb begin
    strb.shiftEn   = sclRise && inByte && !startSeen && !stopSeen;
    strb.loadSub   = byteDone && (state == ST_SUB);
    strb.writeData = byteDone && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_SUB;
      bitCnt   <= 3'd0;
      sdaPull  <= 1'b0;
    end else if (startSeen) begin
      state   <= ST_ADDR;
      bitCnt  <= 3'd0;
      sdaPull <= 1'b0;
    end else if (stopSeen) begin
      state   <= ST_IDLE;
      bitCnt  <= 3'd0;
      sdaPull <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (strb.shiftEn) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (state == ST_ADDR && !addrMatch) begin
                state <= ST_IGNORE;
              end else begin
                state    <= ST_ACK;
                afterAck <= (state == ST_ADDR) ? ST_SUB : ST_DATA;
              end
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            if (!sdaPull) begin
              sdaPull <= 1'b1;
            end else begin
              sdaPull <= 1'b0;
              state   <= afterAck;
              bitCnt  <= 3'd0;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE) && !sdaPull); // R1

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_ADDR) && (bitCnt == 3'd0)); // R9

  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaPull && !strb.writeData); // R2

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPull) |-> !sclLvl); // R10

endmodule

// File: rtl/actl_datapath.sv
module actl_datapath
  import actl_pkg::*;
#(
  parameter int               NUM_REGS  = 7,
  parameter int               PTR_W     = 4,
  parameter logic [6:0]       DEV_ADDR  = 7'h44,
  parameter logic [BYTE_W-1:0] RESET_VAL = 8'hFE
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strb,
  input  logic                       sdaLvl,
  output logic                       addrMatch,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat,
  output logic                       wrStrobe,
  output logic [PTR_W-1:0]           wrIndex
);

  localparam logic [PTR_W-1:0]  LAST_IDX  = PTR_W'(NUM_REGS - 1);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int                INC_BIT   = 4;

  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] shiftNext;
  logic [PTR_W-1:0]  ptr;
  logic              incMode;
  logic              writeHit;
  logic [BYTE_W-1:0] regFile [NUM_REGS];

  assign shiftNext = {shiftReg[BYTE_W-2:0], sdaLvl};
  assign addrMatch = (shiftNext == ADDR_BYTE);
  assign writeHit  = strb.writeData && (ptr <= LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      incMode <= 1'b0;
    end else if (strb.loadSub) begin
      ptr     <= shiftNext[PTR_W-1:0];
      incMode <= shiftNext[INC_BIT];
    end else if (strb.writeData && incMode) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrIndex  <= '0;
    end else begin
      wrStrobe <= writeHit;
      if (writeHit) begin
        wrIndex <= ptr;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[g] <= RESET_VAL;
      end else if (writeHit && ptr == PTR_W'(g)) begin
        regFile[g] <= shiftNext;
      end
    end
    assign regFlat[g*BYTE_W +: BYTE_W] = regFile[g];

    AST_REG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regFile[g]) |-> wrStrobe && (wrIndex == PTR_W'(g))); // R8
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R8

  AST_STROBE_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> wrIndex <= LAST_IDX); // R8

endmodule

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave
  import actl_pkg::*;
#(
  parameter int                NUM_REGS    = 7,
  parameter int                PTR_W       = 4,
  parameter logic [6:0]        DEV_ADDR    = 7'h44,
  parameter logic [BYTE_W-1:0] RESET_VAL   = 8'hFE,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaPullEn,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat,
  output logic                       wrStrobe,
  output logic [PTR_W-1:0]           wrIndex
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen, addrMatch;
  ctrlStrobes_t strb;

  actl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  actl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .addrMatch(addrMatch),
    .strb(strb), .sdaPull(sdaPullEn)
  );

  actl_datapath #(
    .NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR), .RESET_VAL(RESET_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLvl(sdaLvl), .addrMatch(addrMatch),
    .regFlat(regFlat), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

endmodule

// File: tb/audio_ctrl_i2c_slave_bench.sv
module audio_ctrl_i2c_slave_bench;

  localparam int NREG = 7;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaPullEn;
  logic [NREG*8-1:0] regFlat;
  logic wrStrobe;
  logic [3:0] wrIndex;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [11:0] expQ[$];
  logic [7:0] model [NREG];
  logic [3:0] mPtr;
  logic mInc;

  always #10 clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullEn;

  audio_ctrl_i2c_slave u_audio_ctrl_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaPullEn(sdaPullEn), .regFlat(regFlat), .wrStrobe(wrStrobe), .wrIndex(wrIndex)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(posedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitq();
    sclM = 1'b1; waitq();
    sdaM = 1'b0; waitq();
    sclM = 1'b0; waitq();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitq();
    sclM = 1'b1; waitq();
    sdaM = 1'b1; waitq();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitq();
    sclM = 1'b1; waitq();
    waitq();
    sclM = 1'b0; waitq();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    logic ackSeen;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; waitq();
    sclM = 1'b1; waitq();
    @(negedge clk);
    ackSeen = ~sdaBus;
    waitq();
    sclM = 1'b0; waitq();
    check(ackSeen == expAck, req, int'(ackSeen), int'(expAck));
  endtask

  task automatic sendSub(input logic [7:0] s);
    mPtr = s[3:0];
    mInc = s[4];
    sendByte(s, 1'b1, "R4 subaddress ack");
  endtask

  task automatic sendData(input logic [7:0] d);
    if (mPtr < 4'd7) begin
      expQ.push_back({mPtr, d});
      model[mPtr] = d;
    end
    sendByte(d, 1'b1, "R10 data ack");
    if (mInc) mPtr = mPtr + 4'd1;
  endtask

  task automatic checkRegs(input string req);
    @(negedge clk);
    for (int i = 0; i < NREG; i++)
      check(regFlat[i*8 +: 8] == model[i], req, int'(regFlat[i*8 +: 8]), int'(model[i]));
  endtask

  // monitor: pops expected writes as strobes appear (R8)
  always @(negedge clk) begin
    if (rstN && wrStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", int'(wrIndex), 0);
      end else begin
        logic [11:0] e;
        e = expQ.pop_front();
        check(wrIndex == e[11:8], "R8 strobe index", int'(wrIndex), int'(e[11:8]));
        check(regFlat[wrIndex*8 +: 8] == e[7:0], "R5/R6 written value",
              int'(regFlat[wrIndex*8 +: 8]), int'(e[7:0]));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "watchdog", cyc, 150000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'hFE;
    mPtr = 4'd0;
    mInc = 1'b0;
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    repeat (5) @(posedge clk);

    // R7 reset values
    checkRegs("R7 reset value");
    check(sdaPullEn == 1'b0, "R1 idle pull", int'(sdaPullEn), 0);

    // R5: no increment, bits 7:5 set (R4 don't care)
    i2cStart();
    sendByte(8'h88, 1'b1, "R2 address ack");
    sendSub(8'hE3);
    sendData(8'hA1);
    sendData(8'hA2);
    sendData(8'hA3);
    i2cStop();
    waitq();
    check(sdaPullEn == 1'b0, "R1 pull released after stop", int'(sdaPullEn), 0);
    checkRegs("R5 same register");

    // R6: increment from 5, through dropped positions, wrap to 0 and 1
    i2cStart();
    sendByte(8'h88, 1'b1, "R2 address ack");
    sendSub(8'h15);
    for (int k = 0; k < 13; k++) sendData(8'h30 + 8'(k));
    i2cStop();
    waitq();
    checkRegs("R6 increment and wrap");

    // R2: wrong address, bus ignored until next START
    i2cStart();
    sendByte(8'h8A, 1'b0, "R2 wrong address nack");
    sendByte(8'h88, 1'b0, "R2 ignored byte");
    sendByte(8'h02, 1'b0, "R2 ignored byte");
    sendByte(8'h55, 1'b0, "R2 ignored byte");
    i2cStop();
    waitq();
    checkRegs("R2 no change when ignored");

    // R3: read request
    i2cStart();
    sendByte(8'h89, 1'b0, "R3 read nack");
    i2cStop();
    waitq();

    // R9: repeated START
    i2cStart();
    sendByte(8'h88, 1'b1, "R2 address ack");
    sendSub(8'h02);
    sendData(8'h5A);
    i2cStart();
    sendByte(8'h88, 1'b1, "R9 address after restart");
    sendSub(8'h10);
    sendData(8'hC3);
    sendData(8'h3C);
    i2cStart();
    sendByte(8'h11, 1'b0, "R9 restart then wrong address");
    i2cStop();
    waitq();
    checkRegs("R9 repeated start");

    // R11: STOP partway through a data byte
    i2cStart();
    sendByte(8'h88, 1'b1, "R2 address ack");
    sendSub(8'h04);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    i2cStop();
    waitq();
    checkRegs("R11 partial byte discarded");

    // R1: new transfer still works after the aborted one
    i2cStart();
    sendByte(8'h88, 1'b1, "R1 address after stop");
    sendSub(8'h06);
    sendData(8'h77);
    i2cStop();
    waitq();
    checkRegs("R1 transfer after stop");

    check(expQ.size() == 0, "R8 missing strobes", expQ.size(), 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule